// File: doc/BRIEF.md
# Selectable-Rate Periodic Interrupt Generator

This block sits inside a real-time clock and turns its 256 Hz timebase into a slower periodic event. Software picks the event rate by writing a 3-bit code into a byte-wide control register. Each completed period sets a sticky flag. An interrupt line is raised while that flag is set and the chosen rate is not the "off" code.

Software acknowledges an event by writing the control byte with its top bit at 0. Writing a new rate code restarts the internal divider, so the first event at the new rate comes one whole new period after the write. Writing the code that is already selected leaves the divider phase as it is.

The timebase comes in as a one-cycle tick enable in the system clock domain. Register writes are single-cycle strobes that carry the whole control byte.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After synchronous reset the flag and the interrupt are 0 and the rate code is 6. The first event therefore arrives on the 256th tick after reset.
- R2: The rate code sits in control byte bits 6:4. Codes 1, 2, 3, 4, 5 and 6 give one event every 1, 4, 16, 64, 128 and 256 ticks respectively.
- R3: Code 7 gives one event every 512 ticks (one event per 2 seconds).
- R4: Code 0 produces no events. While code 0 is selected the interrupt stays 0 for any number of ticks.
- R5: An event sets the flag on the clock edge that samples the period-completing tick. The flag then stays set until software clears it.
- R6: A write with bit 7 at 0 clears the flag. A write with bit 7 at 1 leaves the flag unchanged. If an event and a clearing write happen in the same cycle, the flag stays set.
- R7: A write whose code differs from the current code restarts the divider, so the next event comes after a full period of the new code. A write that repeats the current code does not disturb the divider phase.
- R8: The interrupt equals flag AND (code not 0). It is registered and updates on the same edge as the flag and the code.
- R9: A tick that arrives in the same cycle as a restarting write is discarded and does not count toward the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per 256 Hz timebase tick |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte: bit 7 flag keep (0 clears), bits 6:4 rate code |
| flag_o | output | 1 | Sticky periodic event flag |
| irq_o | output | 1 | Periodic interrupt request |

## Verification
Two situations are hard to reach: a period-completing tick that lands in the same cycle as a clearing write, and a tick that lands on a restarting write. The scoreboard driver uses rate code 1 to reach the first, because with code 1 every tick completes a period, so any tick coincides with the clear. It reaches the second by selecting a different code and raising the tick together with the write. Divider phase preservation is exposed by counting ticks across a repeated-code write and checking on exactly which tick the flag rises.

// File: rtl/rtc_pirq_pkg.sv
package rtc_pirq_pkg;

  localparam int unsigned SEL_W     = 3;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned SEL_LSB   = 4;
  localparam int unsigned KEEP_BIT  = 7;
  localparam logic [SEL_W-1:0] SEL_RESET = 3'd6;
  localparam int unsigned NUM_CODES = 1 << SEL_W;

  // log2 of the period in ticks for a rate code, given log2 of the tick rate
  function automatic int unsigned rate_log2(input int unsigned code,
                                            input int unsigned base);
    int unsigned r;
    case (code)
      0:       r = 0;
      1, 2, 3, 4: r = 2 * (code - 1);
      5:       r = base - 1;
      6:       r = base;
      default: r = base + 1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_pirq_ctrl.sv
module rtc_pirq_ctrl
  import rtc_pirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [SEL_W-1:0] sel_q,
  output logic [SEL_W-1:0] sel_d,
  output logic             restart,
  output logic             clr
);

  assign sel_d   = wr_en ? wr_data[SEL_LSB +: SEL_W] : sel_q;
  assign restart = wr_en && (sel_d != sel_q);
  assign clr     = wr_en && !wr_data[KEEP_BIT];

  always_ff @(posedge clk) begin
    if (rst) sel_q <= SEL_RESET;
    else     sel_q <= sel_d;
  end

  // Code only changes through a write
  p_sel_write_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(sel_q));

endmodule

// File: rtl/rtc_pirq_divider.sv
module rtc_pirq_divider
  import rtc_pirq_pkg::*;
#(
  parameter int unsigned TICK_LOG2 = 8,
  localparam int unsigned CNT_W    = TICK_LOG2 + 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel_q,
  output logic             event_o
);

  logic [CNT_W-1:0] term_tab [NUM_CODES];
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] cnt_q;

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_term
    localparam int unsigned L = rate_log2(c, TICK_LOG2);
    localparam logic [CNT_W-1:0] T = CNT_W'((64'd1 << L) - 64'd1);
    assign term_tab[c] = T;
  end

  assign term    = term_tab[sel_q];
  assign event_o = tick_en && !restart && (sel_q != '0) && (cnt_q == term);

  always_ff @(posedge clk) begin
    if (rst || restart || sel_q == '0) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      cnt_q <= (cnt_q == term) ? '0 : cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= term);
  p_restart_zero_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt_q == '0);
  p_no_event_off_r4: assert property (@(posedge clk) disable iff (rst)
    sel_q == '0 |-> !event_o);
  p_restart_drop_r9: assert property (@(posedge clk) disable iff (rst)
    restart |-> !event_o);

endmodule

// File: rtl/rtc_pirq_flag.sv
module rtc_pirq_flag
  import rtc_pirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             event_i,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel_d,
  input  logic [SEL_W-1:0] sel_q,
  output logic             flag_q,
  output logic             irq_q
);

  logic flag_d;

  assign flag_d = event_i || (flag_q && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d && (sel_d != '0);
    end
  end

  p_event_sets_r5: assert property (@(posedge clk) disable iff (rst)
    event_i |=> flag_q);
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
    flag_q && !clr |=> flag_q);
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q);
  p_off_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    sel_q == '0 |-> !irq_q);

endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
  import rtc_pirq_pkg::*;
#(
  parameter int unsigned TICK_LOG2 = 8
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             flag_o,
  output logic             irq_o
);

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic             restart;
  logic             clr;
  logic             event_w;

  rtc_pirq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sel_q   (sel_q),
    .sel_d   (sel_d),
    .restart (restart),
    .clr     (clr)
  );

  rtc_pirq_divider #(.TICK_LOG2(TICK_LOG2)) u_div (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .restart (restart),
    .sel_q   (sel_q),
    .event_o (event_w)
  );

  rtc_pirq_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .event_i (event_w),
    .clr     (clr),
    .sel_d   (sel_d),
    .sel_q   (sel_q),
    .flag_q  (flag_o),
    .irq_q   (irq_o)
  );

  // Event wins over a simultaneous clear
  p_event_beats_clear_r6: assert property (@(posedge clk) disable iff (rst)
    event_w && clr |=> flag_o);

endmodule

// File: tb/rtc_periodic_irq_test.sv
module rtc_periodic_irq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       flag_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic  f;
    logic  i;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;  // 200 MHz

  rtc_periodic_irq uut (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .flag_o  (flag_o),
    .irq_o   (irq_o)
  );

  // Monitor: compare outputs against expectations, away from the edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (flag_o !== e.f || irq_o !== e.i) begin
        n_fail++;
        $display("FAIL %s: flag/irq actual %b/%b expected %b/%b",
                 e.tag, flag_o, irq_o, e.f, e.i);
      end
    end
  end

  // Driver: apply one cycle of stimulus and queue the expected outcome
  task automatic drive(input logic t, input logic w, input logic [7:0] d,
                       input logic ef, input logic ei, input string tag);
    @(negedge clk);
    tick_en = t;
    wr_en   = w;
    wr_data = d;
    @(posedge clk);
    #1;
    q.push_back('{ef, ei, tag});
  endtask

  // n ticks: flag stays low until the last one completes the period
  task automatic run_period(input int n, input string tag);
    for (int k = 0; k < n - 1; k++) drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, tag);
    drive(1'b1, 1'b0, 8'h00, 1'b1, 1'b1, tag);
  endtask

  task automatic check_code(input int code, input int n, input string tag);
    logic [7:0] b;
    b = {1'b0, 3'(code), 4'h0};
    drive(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, tag);
    drive(1'b0, 1'b1, b, 1'b0, 1'b0, tag);
    run_period(n, tag);
    drive(1'b0, 1'b1, b, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state, then default code 6 fires on the 256th tick
    drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R1");
    run_period(256, "R1");
    drive(1'b0, 1'b1, 8'h60, 1'b0, 1'b0, "R6");

    // R2: each rate code
    check_code(1, 1,   "R2");
    check_code(2, 4,   "R2");
    check_code(3, 16,  "R2");
    check_code(4, 64,  "R2");
    check_code(5, 128, "R2");
    check_code(6, 256, "R2");
    // R3: code 7
    check_code(7, 512, "R3");

    // R4: code 0 never fires
    drive(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R4");
    for (int k = 0; k < 600; k++) drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R4");

    // R8: irq gated by the code while the flag holds (R5)
    drive(1'b0, 1'b1, 8'h10, 1'b0, 1'b0, "R8");
    drive(1'b1, 1'b0, 8'h00, 1'b1, 1'b1, "R5");
    drive(1'b0, 1'b1, 8'h80, 1'b1, 1'b0, "R8");
    for (int k = 0; k < 5; k++) drive(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R4");
    drive(1'b0, 1'b1, 8'h90, 1'b1, 1'b1, "R8");

    // R6: event beats clear; keep bit leaves flag
    drive(1'b1, 1'b1, 8'h10, 1'b1, 1'b1, "R6");
    drive(1'b0, 1'b1, 8'h10, 1'b0, 1'b0, "R6");
    drive(1'b0, 1'b1, 8'h90, 1'b0, 1'b0, "R6");
    drive(1'b1, 1'b0, 8'h00, 1'b1, 1'b1, "R5");
    drive(1'b0, 1'b1, 8'h90, 1'b1, 1'b1, "R6");
    drive(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R5");
    drive(1'b0, 1'b1, 8'h10, 1'b0, 1'b0, "R6");

    // R7: repeated code keeps phase
    drive(1'b0, 1'b1, 8'h20, 1'b0, 1'b0, "R7");
    drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R7");
    drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R7");
    drive(1'b0, 1'b1, 8'hA0, 1'b0, 1'b0, "R7");
    drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R7");
    drive(1'b1, 1'b0, 8'h00, 1'b1, 1'b1, "R7");
    drive(1'b0, 1'b1, 8'h20, 1'b0, 1'b0, "R7");
    // R7: new code restarts mid-period
    drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R7");
    drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R7");
    drive(1'b0, 1'b1, 8'h30, 1'b0, 1'b0, "R7");
    run_period(16, "R7");
    drive(1'b0, 1'b1, 8'h30, 1'b0, 1'b0, "R7");

    // R9: tick on a restarting write is dropped
    drive(1'b0, 1'b1, 8'h20, 1'b0, 1'b0, "R9");
    drive(1'b1, 1'b1, 8'h10, 1'b0, 1'b0, "R9");
    drive(1'b1, 1'b0, 8'h00, 1'b1, 1'b1, "R9");

    drive(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R5");
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule